// File: doc/BRIEF.md
# AFSK HDLC Frame Transmitter

This block turns bytes from a transmit FIFO into a stream of 8-bit unsigned audio samples carrying an audio frequency-shift keyed HDLC frame. A start strobe begins a transmission. The block sends a programmable number of opening flag bytes, then everything the FIFO holds, then a programmable number of closing flag bytes. Bits go out least significant first. Each bit occupies a fixed number of sample periods. A zero bit switches the tone between mark and space, and a one bit keeps the tone. A zero period is inserted after five consecutive ones, except while flag or abort bytes are being sent.

One sample is produced per sample-clock enable. A phase accumulator and a sine lookup synthesise the tone. While the block is transmitting, `busy` is high and can drive the transmitter's push-to-talk line. `done` pulses once when the frame ends. An escape byte in the FIFO is never sent: it forces the byte that follows it out literally, with zero insertion left on.

Top module: `afsk_frame_tx`

## Requirements
- R1: After reset, `busy` and `done` are 0, `fifo_rd` is 0 and `sample_out` is 128.
- R2: A `start` pulse while idle raises `busy` on the next clock. It selects the mark tone and clears the phase and the ones-run count. The first `sample_en` is allowed from the third clock after the `start` clock onward. A `start` while busy has no effect.
- R3: Every `sample_en` while busy adds the tone increment to an 8-bit phase, modulo 256. The increment is 32 for mark and 59 for space. `sample_out` is then 128 + round(127·sin(2π·k/64)), where k is the phase shifted right by two. Each bit period lasts 8 enables.
- R4: Bits are taken least significant bit first. A 0 bit toggles the tone, and a 1 bit keeps it. The tone changes only on a bit decision.
- R5: While zero insertion is on, five consecutive 1 bits are followed by an extra bit period. That period toggles the tone, clears the run and consumes no data bit.
- R6: Bytes are chosen in this order at each byte boundary. While the opening count is nonzero, 0x7E is sent and the count decrements. Otherwise, if the FIFO is non-empty, its head byte is popped and sent. Otherwise 0x7E is sent and the closing count decrements. Both counts are in bytes.
- R7: Zero insertion is off for a byte equal to 0x7E or 0x7F taken from a count or from the FIFO. When a later byte turns insertion back on, the ones-run count restarts from zero.
- R8: An escape byte 0x1B popped from the FIFO is not sent. The next FIFO byte is sent in its place, with zero insertion on, even if it equals 0x7E or 0x7F.
- R9: If an escape byte is popped and the FIFO is then empty, the transmission ends at that byte boundary, and no closing flags are sent.
- R10: When a byte boundary is reached with the FIFO empty and the closing count zero, the transmission ends on that enable. `busy` falls, `done` is high for exactly one clock, and `sample_out` returns to 128. `fifo_rd` is asserted only when `fifo_empty` is 0.
- R11: `sample_out` holds its value on clocks without `sample_en` or `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (ignored while busy) |
| pre_cnt | input | 8 | Number of opening flag bytes, sampled at start |
| tail_cnt | input | 8 | Number of closing flag bytes, sampled at start |
| sample_en | input | 1 | Sample-clock enable, one pulse per output sample |
| fifo_empty | input | 1 | Transmit FIFO holds no byte |
| fifo_data | input | 8 | Head byte of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pop the head byte this clock |
| sample_out | output | 8 | Unsigned audio sample, 128 at rest |
| busy | output | 1 | Transmission in progress (push-to-talk) |
| done | output | 1 | One-clock pulse when a frame ends |

## Verification
The load of a new byte and a zero-insertion period can fall on the same bit decision. This happens when one byte ends with five ones and the next byte keeps insertion on. The last data bit and the end of the frame can also share a cycle, when the closing count reaches zero at the same boundary. The bench sweeps every value of a first payload byte followed by 0xFF, which drives runs of every length across the byte boundary. Frames with escape and abort bytes set up the other overlaps. Every enable's sample is compared with an arithmetic model of the tone sequence. The end is judged by the exact enable on which `busy` falls and `done` pulses.

// File: rtl/afsk_tx_pkg.sv
package afsk_tx_pkg;
  localparam logic [7:0] FLAG_BYTE  = 8'h7E;
  localparam logic [7:0] ABORT_BYTE = 8'h7F;
  localparam logic [7:0] ESC_BYTE   = 8'h1B;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_WAIT,
    FS_SEL,
    FS_ESC,
    FS_RDY,
    FS_FIN
  } fetch_st_t;
endpackage

// File: rtl/afsk_byte_fetch.sv
module afsk_byte_fetch
  import afsk_tx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             last_bit,
  input  logic             take,
  input  logic [CNT_W-1:0] pre_cnt,
  input  logic [CNT_W-1:0] tail_cnt,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_data,
  output logic             fifo_rd,
  output logic             byte_rdy,
  output logic             byte_fin,
  output logic [7:0]       byte_val,
  output logic             byte_nostuff
);
  fetch_st_t        st_q, st_n;
  logic [CNT_W-1:0] pre_q, pre_n, tail_q, tail_n;
  logic [7:0]       byte_q, byte_n;
  logic             nost_q, nost_n;

  always_comb begin
    st_n    = st_q;
    pre_n   = pre_q;
    tail_n  = tail_q;
    byte_n  = byte_q;
    nost_n  = nost_q;
    fifo_rd = 1'b0;
    case (st_q)
      FS_IDLE: begin
        if (go) begin
          pre_n  = pre_cnt;
          tail_n = tail_cnt;
          st_n   = FS_SEL;
        end
      end
      FS_WAIT: begin
        if (last_bit) st_n = FS_SEL;
      end
      FS_SEL: begin
        if (pre_q != '0) begin
          pre_n  = pre_q - 1'b1;
          byte_n = FLAG_BYTE;
          nost_n = 1'b1;
          st_n   = FS_RDY;
        end else if (!fifo_empty) begin
          fifo_rd = 1'b1;
          if (fifo_data == ESC_BYTE) begin
            st_n = FS_ESC;
          end else begin
            byte_n = fifo_data;
            nost_n = (fifo_data == FLAG_BYTE) || (fifo_data == ABORT_BYTE);
            st_n   = FS_RDY;
          end
        end else if (tail_q != '0) begin
          tail_n = tail_q - 1'b1;
          byte_n = FLAG_BYTE;
          nost_n = 1'b1;
          st_n   = FS_RDY;
        end else begin
          st_n = FS_FIN;
        end
      end
      FS_ESC: begin
        if (!fifo_empty) begin
          fifo_rd = 1'b1;
          byte_n  = fifo_data;
          nost_n  = 1'b0;
          st_n    = FS_RDY;
        end else begin
          st_n = FS_FIN;
        end
      end
      FS_RDY: begin
        if (take) st_n = FS_WAIT;
      end
      FS_FIN: begin
        if (take) st_n = FS_IDLE;
      end
      default: st_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      pre_q  <= '0;
      tail_q <= '0;
      byte_q <= '0;
      nost_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      pre_q  <= pre_n;
      tail_q <= tail_n;
      byte_q <= byte_n;
      nost_q <= nost_n;
    end
  end

  assign byte_rdy     = (st_q == FS_RDY);
  assign byte_fin     = (st_q == FS_FIN);
  assign byte_val     = byte_q;
  assign byte_nostuff = nost_q;

  assert_rd_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);

  assert_ready_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_rdy && !take) |=> (byte_rdy && $stable(byte_val)));
endmodule

// File: rtl/afsk_bit_engine.sv
module afsk_bit_engine #(
  parameter int SPB       = 8,
  parameter int STUFF_RUN = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       sample_en,
  input  logic       f_rdy,
  input  logic       f_fin,
  input  logic [7:0] f_byte,
  input  logic       f_nostuff,
  output logic       go,
  output logic       take,
  output logic       last_bit,
  output logic       adv,
  output logic       tone_nxt,
  output logic       stop,
  output logic       active,
  output logic       done
);
  localparam int SIDX_W = (SPB > 1) ? $clog2(SPB) : 1;
  localparam int RUN_W  = $clog2(STUFF_RUN + 1);
  localparam logic [RUN_W-1:0]  RUN_MAX  = {RUN_W{1'b1}};
  localparam logic [RUN_W-1:0]  RUN_LIM  = RUN_W'(STUFF_RUN);
  localparam logic [SIDX_W-1:0] SIDX_TOP = SIDX_W'(SPB - 1);

  logic              act_q, act_n;
  logic              done_q, done_n;
  logic              tone_q, tone_n;
  logic              stuff_q, stuff_n, stuff_e;
  logic [RUN_W-1:0]  run_q, run_n, run_e;
  logic [7:0]        mask_q, mask_n, mask_e;
  logic [7:0]        byte_q, byte_n, byte_e;
  logic [SIDX_W-1:0] sidx_q, sidx_n;
  logic              boundary;

  assign boundary = (sidx_q == '0) && (mask_q == '0);
  assign go       = start && !act_q;

  always_comb begin
    act_n   = act_q;
    done_n  = 1'b0;
    tone_n  = tone_q;
    stuff_n = stuff_q;
    run_n   = run_q;
    mask_n  = mask_q;
    byte_n  = byte_q;
    sidx_n  = sidx_q;
    take    = 1'b0;
    adv     = 1'b0;
    stuff_e = stuff_q;
    run_e   = run_q;
    mask_e  = mask_q;
    byte_e  = byte_q;
    if (!act_q) begin
      if (start) begin
        act_n   = 1'b1;
        tone_n  = 1'b0;
        stuff_n = 1'b0;
        run_n   = '0;
        mask_n  = '0;
        sidx_n  = '0;
      end
    end else if (sample_en) begin
      if (boundary) begin
        take = 1'b1;
        if (f_fin) begin
          act_n  = 1'b0;
          done_n = 1'b1;
        end else begin
          byte_e  = f_byte;
          mask_e  = 8'h01;
          if (!stuff_q) run_e = '0;
          stuff_e = !f_nostuff;
        end
      end
      if (!(boundary && f_fin)) begin
        adv = 1'b1;
        if (sidx_q == '0) begin
          if (stuff_e && (run_e >= RUN_LIM)) begin
            run_e  = '0;
            tone_n = !tone_q;
          end else begin
            if ((byte_e & mask_e) != '0) begin
              if (run_e != RUN_MAX) run_e = run_e + 1'b1;
            end else begin
              run_e  = '0;
              tone_n = !tone_q;
            end
            mask_e = mask_e << 1;
          end
          sidx_n = SIDX_TOP;
        end else begin
          sidx_n = sidx_q - 1'b1;
        end
        byte_n  = byte_e;
        mask_n  = mask_e;
        run_n   = run_e;
        stuff_n = stuff_e;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      done_q  <= 1'b0;
      tone_q  <= 1'b0;
      stuff_q <= 1'b0;
      run_q   <= '0;
      mask_q  <= '0;
      byte_q  <= '0;
      sidx_q  <= '0;
    end else begin
      act_q   <= act_n;
      done_q  <= done_n;
      tone_q  <= tone_n;
      stuff_q <= stuff_n;
      run_q   <= run_n;
      mask_q  <= mask_n;
      byte_q  <= byte_n;
      sidx_q  <= sidx_n;
    end
  end

  assign last_bit = act_q && (mask_q == '0);
  assign tone_nxt = tone_n;
  assign stop     = done_n;
  assign active   = act_q;
  assign done     = done_q;

  assert_take_has_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (f_rdy || f_fin));

  assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_q |-> (run_q <= RUN_LIM));

  assert_tone_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !sample_en) |=> $stable(tone_q));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !act_q);
endmodule

// File: rtl/afsk_tone_nco.sv
module afsk_tone_nco #(
  parameter int PH_W      = 8,
  parameter int ROM_AW    = 6,
  parameter int OUT_W     = 8,
  parameter int MARK_INC  = 32,
  parameter int SPACE_INC = 59,
  parameter int AMP       = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic             space,
  input  logic             stop,
  output logic [OUT_W-1:0] sample
);
  localparam int ROM_N = 1 << ROM_AW;
  localparam int MID   = 1 << (OUT_W - 1);
  localparam logic [OUT_W-1:0] MID_V = OUT_W'(MID);

  logic [OUT_W-1:0] rom [ROM_N];

  for (genvar gi = 0; gi < ROM_N; gi++) begin : g_rom
    localparam real ANG = 6.283185307179586 * real'(gi) / real'(ROM_N);
    localparam int  VAL = MID + int'(real'(AMP) * $sin(ANG));
    assign rom[gi] = OUT_W'(VAL);
  end

  logic [PH_W-1:0]  phase_q, phase_n;
  logic [OUT_W-1:0] sample_q, sample_n;

  always_comb begin
    phase_n  = phase_q;
    sample_n = sample_q;
    if (clr) begin
      phase_n  = '0;
      sample_n = MID_V;
    end else if (stop) begin
      sample_n = MID_V;
    end else if (adv) begin
      phase_n  = phase_q + (space ? PH_W'(SPACE_INC) : PH_W'(MARK_INC));
      sample_n = rom[phase_n[PH_W-1 -: ROM_AW]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      sample_q <= MID_V;
    end else begin
      phase_q  <= phase_n;
      sample_q <= sample_n;
    end
  end

  assign sample = sample_q;

  assert_sample_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr && !stop) |=> $stable(sample_q));

  assert_rest_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (sample_q == MID_V));
endmodule

// File: rtl/afsk_frame_tx.sv
module afsk_frame_tx #(
  parameter int CNT_W     = 8,
  parameter int SPB       = 8,
  parameter int STUFF_RUN = 5,
  parameter int PH_W      = 8,
  parameter int ROM_AW    = 6,
  parameter int OUT_W     = 8,
  parameter int MARK_INC  = 32,
  parameter int SPACE_INC = 59,
  parameter int AMP       = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] pre_cnt,
  input  logic [CNT_W-1:0] tail_cnt,
  input  logic             sample_en,
  input  logic             fifo_empty,
  input  logic [7:0]       fifo_data,
  output logic             fifo_rd,
  output logic [OUT_W-1:0] sample_out,
  output logic             busy,
  output logic             done
);
  logic       go, take, last_bit, adv, tone_nxt, stop;
  logic       f_rdy, f_fin, f_nostuff;
  logic [7:0] f_byte;

  afsk_byte_fetch #(.CNT_W(CNT_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go),
    .last_bit     (last_bit),
    .take         (take),
    .pre_cnt      (pre_cnt),
    .tail_cnt     (tail_cnt),
    .fifo_empty   (fifo_empty),
    .fifo_data    (fifo_data),
    .fifo_rd      (fifo_rd),
    .byte_rdy     (f_rdy),
    .byte_fin     (f_fin),
    .byte_val     (f_byte),
    .byte_nostuff (f_nostuff)
  );

  afsk_bit_engine #(.SPB(SPB), .STUFF_RUN(STUFF_RUN)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sample_en (sample_en),
    .f_rdy     (f_rdy),
    .f_fin     (f_fin),
    .f_byte    (f_byte),
    .f_nostuff (f_nostuff),
    .go        (go),
    .take      (take),
    .last_bit  (last_bit),
    .adv       (adv),
    .tone_nxt  (tone_nxt),
    .stop      (stop),
    .active    (busy),
    .done      (done)
  );

  afsk_tone_nco #(
    .PH_W      (PH_W),
    .ROM_AW    (ROM_AW),
    .OUT_W     (OUT_W),
    .MARK_INC  (MARK_INC),
    .SPACE_INC (SPACE_INC),
    .AMP       (AMP)
  ) u_nco (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (go),
    .adv    (adv),
    .space  (tone_nxt),
    .stop   (stop),
    .sample (sample_out)
  );

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/afsk_frame_tx_test.sv
module afsk_frame_tx_test;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, start, sample_en;
  logic [7:0] pre_cnt, tail_cnt;
  logic       fifo_empty, fifo_rd, busy, done;
  logic [7:0] fifo_data, sample_out;

  afsk_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .start(start), .pre_cnt(pre_cnt),
    .tail_cnt(tail_cnt), .sample_en(sample_en), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_rd(fifo_rd), .sample_out(sample_out),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [7:0] mem [0:1023];
  int wr_ptr = 0;
  int rd_ptr;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) rd_ptr <= 0;
    else if (fifo_rd) rd_ptr <= rd_ptr + 1;
  assign fifo_empty = (rd_ptr == wr_ptr);
  assign fifo_data  = mem[rd_ptr % 1024];

  int total = 0, bad = 0;
  int exp_s [0:4095];
  int exp_n;
  int pay [0:15];
  int pay_n;

  function automatic int sine_of(int ph);
    return 128 + int'(127.0 * $sin(6.283185307179586 * real'(ph >> 2) / 64.0));
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Expected sample list from the requirements (R3..R9)
  task automatic build(int pre, int tail);
    int eb [0:63];
    int es [0:63];
    int ne, i, tone, run, st, ph, k;
    bit term;
    ne = 0; term = 0;
    for (int p = 0; p < pre; p++) begin eb[ne] = 8'h7E; es[ne] = 0; ne++; end
    i = 0;
    while (i < pay_n && !term) begin
      if (pay[i] == 8'h1B) begin
        if (i + 1 < pay_n) begin eb[ne] = pay[i+1]; es[ne] = 1; ne++; i += 2; end
        else term = 1;
      end else begin
        eb[ne] = pay[i];
        es[ne] = (pay[i] == 8'h7E || pay[i] == 8'h7F) ? 0 : 1;
        ne++; i++;
      end
    end
    if (!term) for (int p = 0; p < tail; p++) begin eb[ne] = 8'h7E; es[ne] = 0; ne++; end
    tone = 0; run = 0; st = 0; ph = 0; exp_n = 0;
    for (int e = 0; e < ne; e++) begin
      if (st == 0) run = 0;
      st = es[e];
      k = 0;
      while (k < 8) begin
        if (st != 0 && run >= 5) begin
          run = 0; tone ^= 1;
        end else begin
          if (((eb[e] >> k) & 1) != 0) run++;
          else begin run = 0; tone ^= 1; end
          k++;
        end
        for (int s = 0; s < 8; s++) begin
          ph = (ph + (tone != 0 ? 59 : 32)) % 256;
          exp_s[exp_n] = sine_of(ph);
          exp_n++;
        end
      end
    end
  endtask

  task automatic run_frame(string tag, int pre, int tail);
    int errs, herrs, fa, fe, last;
    for (int j = 0; j < pay_n; j++) begin mem[wr_ptr % 1024] = 8'(pay[j]); wr_ptr++; end
    build(pre, tail);
    @(negedge clk);
    pre_cnt = 8'(pre); tail_cnt = 8'(tail); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, {"R2 busy after start ", tag}, int'(busy), 1);
    @(negedge clk);
    @(negedge clk);
    errs = 0; herrs = 0; fa = 0; fe = 0;
    for (int n = 0; n < exp_n; n++) begin
      sample_en = 1'b1;
      @(negedge clk);
      sample_en = 1'b0;
      if (int'(sample_out) != exp_s[n] || !busy) begin
        if (errs == 0) begin fa = int'(sample_out); fe = exp_s[n]; end
        errs++;
      end
      last = int'(sample_out);
      @(negedge clk);
      if (int'(sample_out) != last) herrs++;
    end
    check(errs == 0, {"R3 R4 R5 R6 R7 R8 sample stream ", tag}, fa, fe);
    check(herrs == 0, {"R11 hold between enables ", tag}, herrs, 0);
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    check(busy == 1'b0 && done == 1'b1, {"R10 end busy/done ", tag},
          int'({busy, done}), 1);
    check(sample_out == 8'd128, {"R10 rest level ", tag}, int'(sample_out), 128);
    check(fifo_empty == 1'b1, {"R9 fifo drained ", tag}, int'(fifo_empty), 1);
    @(negedge clk);
    check(done == 1'b0, {"R10 done one clock ", tag}, int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; sample_en = 1'b0; pre_cnt = '0; tail_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && fifo_rd == 1'b0, "R1 reset flags",
          int'({busy, done, fifo_rd}), 0);
    check(sample_out == 8'd128, "R1 reset sample", int'(sample_out), 128);

    pay[0] = 8'h41; pay[1] = 8'hFF; pay[2] = 8'h3C; pay_n = 3;
    run_frame("R6 basic", 1, 1);
    pay_n = 0;
    run_frame("R6 flags only", 2, 1);
    pay[0] = 8'h7F; pay[1] = 8'hFF; pay_n = 2;
    run_frame("R7 abort byte", 0, 0);
    pay[0] = 8'h1B; pay[1] = 8'h7E; pay[2] = 8'h55; pay_n = 3;
    run_frame("R8 escaped flag", 1, 1);
    pay[0] = 8'h10; pay[1] = 8'h1B; pay_n = 2;
    run_frame("R9 escape at end", 1, 2);

    // R2: start while busy is ignored, frame still matches
    pay[0] = 8'hA5; pay_n = 1;
    for (int j = 0; j < pay_n; j++) begin mem[wr_ptr % 1024] = 8'(pay[j]); wr_ptr++; end
    build(0, 1);
    @(negedge clk); pre_cnt = 0; tail_cnt = 1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); @(negedge clk);
    begin
      int errs; errs = 0;
      for (int n = 0; n < exp_n; n++) begin
        sample_en = 1'b1;
        if (n == 20) start = 1'b1;
        @(negedge clk);
        sample_en = 1'b0; start = 1'b0;
        if (int'(sample_out) != exp_s[n]) errs++;
        @(negedge clk);
      end
      check(errs == 0, "R2 start while busy ignored", errs, 0);
      sample_en = 1'b1; @(negedge clk); sample_en = 1'b0;
      check(done == 1'b1, "R10 end after ignored start", int'(done), 1);
      @(negedge clk);
    end

    // R5 sweep: every first byte followed by a run of ones
    for (int b = 0; b < 256; b++) begin
      pay[0] = b; pay[1] = 8'hFF; pay_n = 2;
      run_frame("R5 sweep", 0, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule